// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block chooses the three settings of a pixel-clock synthesizer: a reference divider, a loop multiplier and an output divider. Given a requested pixel clock and the reference clock, both in kHz, it returns the triple whose output frequency comes closest to the request. The output frequency of a triple is modelled with truncating integer arithmetic: the reference is divided by the reference divider, that quotient is multiplied by the loop multiplier, and the product is divided by the output divider.

A small preset table of common display clocks is looked up first. A hit returns the stored triple at once. On a miss the engine walks every legal triple in a fixed order. It evaluates one candidate at a time through a single shared multi-cycle divider and keeps the best result. An exact match ends the walk early. A result counts as found only if its error is under a fixed tolerance.

A controller pulses `start` with the request and waits for the one-cycle `done` pulse. The result outputs stay put from one `done` to the next.

Top module: `pll_param_search`

## Requirements
- R1: A swept candidate's frequency is floor(floor(ref_khz / div_ref) * loopc / div_out), with both divisions truncating (for example ref 100000 with 4, 50, 7 gives 178571).
- R2: The sweep order is: output divider 6 to 63 outermost, reference divider 3 to 5 in the middle, loop multiplier ascending innermost.
- R3: Only loop multiplier values from 12*div_ref to 32*div_ref inclusive, kept inside 6..160, are evaluated; 32*div_ref is itself a legal value.
- R4: The best candidate changes only on a strictly smaller absolute error, so among equal errors the triple reached first in sweep order is reported.
- R5: At the end of a full sweep, if the smallest error is below 1000 kHz, the result is found=1, that triple, and err_khz equal to that error (a best error of 999 is accepted).
- R6: If no candidate has an error below 1000 kHz, the result is found=0, div_ref=loopc=div_out=0 and err_khz=1000.
- R7: The first candidate with zero error ends the search at once with found=1, that triple and err_khz=0.
- R8: The request is first compared for equality with a preset table, listed as clock: (div_ref, loopc, div_out): 25175:(5,107,85), 25200:(5,63,50), 27000:(4,54,50), 40000:(3,36,30), 65000:(3,39,20), 74250:(3,49,22), 108000:(5,81,15), 141750:(5,78,11), 148500:(3,49,11), 174500:(3,89,17). A hit returns the stored triple with found=1 and err_khz=0, whatever the reference clock.
- R9: A start pulse while busy is ignored; the running search finishes with the result of the request that started it.
- R10: busy rises in the cycle after an accepted start and is low in the cycle of the one-cycle done pulse. found, the triple and err_khz change only in the done cycle and otherwise hold.
- R11: After reset busy, done and found are 0, and the triple and err_khz are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when not busy |
| req_khz | input | CLK_W (20) | Requested pixel clock in kHz |
| ref_khz | input | REF_W (17) | Reference clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| found | output | 1 | Result within tolerance |
| div_ref | output | 7 | Chosen reference divider |
| loopc | output | 9 | Chosen loop multiplier |
| div_out | output | 7 | Chosen output divider |
| err_khz | output | REF_W+9 (26) | Absolute error of the result in kHz |

## Verification
Preset clocks are requested under two reference clocks. For 148500 and 65000 the table triple differs from what a sweep would return, so these requests show whether the table is really consulted first. Requests that a candidate hits exactly near the start of the sweep, and also again later, show the early exit and the first-wins tie rule. One of them also depends on truncation in the first division. Two full sweeps sit one kHz on either side of the tolerance edge above the highest reachable frequency. They separate acceptance from failure, show the tie between two reference dividers, and show the upper multiplier limit. A start pulse issued in the middle of the failing sweep shows that a busy engine ignores it.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int DREF_W = 7;
  localparam int LC_W   = 9;
  localparam int DOUT_W = 7;

  typedef struct packed {
    logic [DREF_W-1:0] dref;
    logic [LC_W-1:0]   lc;
    logic [DOUT_W-1:0] dout;
  } pll_set_t;

  typedef struct packed {
    logic     hit;
    pll_set_t set;
  } preset_t;

  function automatic pll_set_t mk_set(input int a, input int b, input int c);
    pll_set_t s;
    s.dref = DREF_W'(a);
    s.lc   = LC_W'(b);
    s.dout = DOUT_W'(c);
    return s;
  endfunction

  // Preset clocks, looked up by exact equality.
  function automatic preset_t preset_find(input logic [31:0] khz);
    preset_t r;
    r.hit = 1'b1;
    r.set = '0;
    case (khz)
      32'd25175:  r.set = mk_set(5, 107, 85);
      32'd25200:  r.set = mk_set(5, 63, 50);
      32'd27000:  r.set = mk_set(4, 54, 50);
      32'd40000:  r.set = mk_set(3, 36, 30);
      32'd65000:  r.set = mk_set(3, 39, 20);
      32'd74250:  r.set = mk_set(3, 49, 22);
      32'd108000: r.set = mk_set(5, 81, 15);
      32'd141750: r.set = mk_set(5, 78, 11);
      32'd148500: r.set = mk_set(3, 49, 11);
      32'd174500: r.set = mk_set(3, 89, 17);
      default:    r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pps_preset_rom.sv
module pps_preset_rom import pps_pkg::*; #(
  parameter int CLK_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CLK_W-1:0] key,
  output logic             hit,
  output pll_set_t         set
);
  preset_t rd;

  // Registered read port, ROM style.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd <= '0;
    end else if (en) begin
      rd <= preset_find(32'(key));
    end
  end

  assign hit = rd.hit;
  assign set = rd.set;
endmodule

// File: rtl/pps_divider.sv
module pps_divider #(
  parameter int DW   = 26,
  parameter int VW   = 7,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [VW-1:0] den,
  output logic          done,
  output logic [DW-1:0] quot
);
  localparam int ITERS = DW / STEP;
  localparam int CW    = $clog2(ITERS + 1);

  logic [DW-1:0] q, q_n, num_q;
  logic [VW-1:0] r, r_n, d;
  logic [CW-1:0] cnt;

  // STEP restoring steps per cycle.
  always_comb begin
    logic [VW:0] rs;
    q_n = q;
    r_n = r;
    for (int i = 0; i < STEP; i++) begin
      rs  = {r_n, q_n[DW-1]};
      q_n = {q_n[DW-2:0], 1'b0};
      if (rs >= {1'b0, d}) begin
        rs     = rs - {1'b0, d};
        q_n[0] = 1'b1;
      end
      r_n = rs[VW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      r     <= '0;
      d     <= '0;
      num_q <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q     <= num;
        num_q <= num;
        r     <= '0;
        d     <= den;
        cnt   <= CW'(ITERS);
      end else if (cnt != '0) begin
        q   <= q_n;
        r   <= r_n;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign quot = q;

  // R1: quotient and remainder reconstruct the latched dividend.
  p_div_exact_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> (({{VW{1'b0}}, q} * {{DW{1'b0}}, d}) + {{DW{1'b0}}, r} == {{VW{1'b0}}, num_q})
             && (r < d));
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pps_best_track.sv
module pps_best_track import pps_pkg::*; #(
  parameter int DW  = 26,
  parameter int TOL = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          eval,
  input  logic [DW-1:0] cand,
  input  logic [DW-1:0] req,
  input  pll_set_t      set_in,
  output logic [DW-1:0] diff,
  output logic          better,
  output logic          exact,
  output logic [DW-1:0] min_err,
  output pll_set_t      best
);
  assign diff   = (cand >= req) ? (cand - req) : (req - cand);
  assign better = diff < min_err;
  assign exact  = (diff == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      min_err <= DW'(TOL);
      best    <= '0;
    end else if (eval && better) begin
      min_err <= diff;
      best    <= set_in;
    end
  end

  // R4: the minimum never grows within a search, and equal errors keep the first triple.
  p_min_nonincr_r4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (min_err <= $past(min_err)));
  p_keep_first_r4: assert property (@(posedge clk) disable iff (rst)
    (eval && !better && !clr) |=> $stable(best));
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search import pps_pkg::*; #(
  parameter int CLK_W     = 20,
  parameter int REF_W     = 17,
  parameter int STEP      = 2,
  parameter int TOL       = 1000,
  parameter int DOUT_MIN  = 6,
  parameter int DOUT_MAX  = 63,
  parameter int DREF_MIN  = 3,
  parameter int DREF_MAX  = 5,
  parameter int LC_MIN    = 6,
  parameter int LC_MAX    = 160,
  parameter int LC_LO_MUL = 12,
  parameter int LC_HI_MUL = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [CLK_W-1:0]      req_khz,
  input  logic [REF_W-1:0]      ref_khz,
  output logic                  busy,
  output logic                  done,
  output logic                  found,
  output logic [DREF_W-1:0]     div_ref,
  output logic [LC_W-1:0]       loopc,
  output logic [DOUT_W-1:0]     div_out,
  output logic [REF_W+LC_W-1:0] err_khz
);
  localparam int DW = REF_W + LC_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_QREF, S_WREF, S_QCAND, S_WCAND} st_t;
  st_t st;

  logic [CLK_W-1:0]  req_q;
  logic [REF_W-1:0]  ref_q, base;
  logic [DOUT_W-1:0] dout;
  logic [DREF_W-1:0] dref;
  logic [LC_W-1:0]   lc, lc_first, lc_last;

  logic              tbl_hit;
  pll_set_t          tbl_set, cur, best, fin_set;
  logic              div_start, div_done;
  logic [DW-1:0]     div_num, quot, diff, min_err, fin_err;
  logic [DOUT_W-1:0] div_den;
  logic              better, exact, fin_ok, eval;
  logic              unused_q_hi;

  assign busy = (st != S_IDLE);
  assign cur  = '{dref: dref, lc: lc, dout: dout};

  // Legal multiplier window for the current reference divider.
  always_comb begin
    int lo, hi;
    lo = LC_LO_MUL * int'(dref);
    if (lo < LC_MIN) lo = LC_MIN;
    hi = LC_HI_MUL * int'(dref);
    if (hi > LC_MAX) hi = LC_MAX;
    lc_first = LC_W'(lo);
    lc_last  = LC_W'(hi);
  end

  pps_preset_rom #(.CLK_W(CLK_W)) u_rom (
    .clk (clk),
    .rst (rst),
    .en  (st == S_IDLE && start),
    .key (req_khz),
    .hit (tbl_hit),
    .set (tbl_set)
  );

  // One divider serves both the reference split and each candidate.
  assign div_start = (st == S_QREF) || (st == S_QCAND);
  assign div_num   = (st == S_QREF) ? DW'(ref_q)
                   : ({{LC_W{1'b0}}, base} * {{REF_W{1'b0}}, lc});
  assign div_den   = (st == S_QREF) ? DOUT_W'(dref) : dout;

  pps_divider #(.DW(DW), .VW(DOUT_W), .STEP(STEP)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quot  (quot)
  );

  assign unused_q_hi = |quot[DW-1:REF_W];
  assign eval        = (st == S_WCAND) && div_done;

  pps_best_track #(.DW(DW), .TOL(TOL)) u_best (
    .clk     (clk),
    .rst     (rst),
    .clr     (st == S_LOOK),
    .eval    (eval),
    .cand    (quot),
    .req     (DW'(req_q)),
    .set_in  (cur),
    .diff    (diff),
    .better  (better),
    .exact   (exact),
    .min_err (min_err),
    .best    (best)
  );

  // Outcome of the last candidate of a full sweep.
  always_comb begin
    fin_err = better ? diff : min_err;
    fin_ok  = fin_err < DW'(TOL);
    fin_set = fin_ok ? (better ? cur : best) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      req_q   <= '0;
      ref_q   <= '0;
      base    <= '0;
      dout    <= '0;
      dref    <= '0;
      lc      <= '0;
      done    <= 1'b0;
      found   <= 1'b0;
      div_ref <= '0;
      loopc   <= '0;
      div_out <= '0;
      err_khz <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          req_q <= req_khz;
          ref_q <= ref_khz;
          st    <= S_LOOK;
        end
        S_LOOK: if (tbl_hit) begin
          done    <= 1'b1;
          found   <= 1'b1;
          div_ref <= tbl_set.dref;
          loopc   <= tbl_set.lc;
          div_out <= tbl_set.dout;
          err_khz <= '0;
          st      <= S_IDLE;
        end else begin
          dout <= DOUT_W'(DOUT_MIN);
          dref <= DREF_W'(DREF_MIN);
          st   <= S_QREF;
        end
        S_QREF: st <= S_WREF;
        S_WREF: if (div_done) begin
          base <= quot[REF_W-1:0];
          lc   <= lc_first;
          st   <= S_QCAND;
        end
        S_QCAND: st <= S_WCAND;
        S_WCAND: if (div_done) begin
          if (better && exact) begin
            done    <= 1'b1;
            found   <= 1'b1;
            div_ref <= dref;
            loopc   <= lc;
            div_out <= dout;
            err_khz <= '0;
            st      <= S_IDLE;
          end else if (lc != lc_last) begin
            lc <= lc + LC_W'(1);
            st <= S_QCAND;
          end else if (dref != DREF_W'(DREF_MAX)) begin
            dref <= dref + DREF_W'(1);
            st   <= S_QREF;
          end else if (dout != DOUT_W'(DOUT_MAX)) begin
            dout <= dout + DOUT_W'(1);
            dref <= DREF_W'(DREF_MIN);
            st   <= S_QREF;
          end else begin
            done    <= 1'b1;
            found   <= fin_ok;
            div_ref <= fin_set.dref;
            loopc   <= fin_set.lc;
            div_out <= fin_set.dout;
            err_khz <= fin_err;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: sweep indices stay inside their ranges while a candidate is evaluated.
  p_sweep_range_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_WCAND) |-> (int'(dout) >= DOUT_MIN && int'(dout) <= DOUT_MAX
                         && int'(dref) >= DREF_MIN && int'(dref) <= DREF_MAX));
  // R3: the multiplier respects the window coupled to the reference divider.
  p_lc_window_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_WCAND) |-> (int'(lc) >= LC_LO_MUL * int'(dref)
                         && int'(lc) <= LC_HI_MUL * int'(dref)));
  p_found_tol_r5: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> (err_khz < DW'(TOL)));
  p_fail_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (err_khz == DW'(TOL) && div_ref == '0 && loopc == '0 && div_out == '0));
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(req_q) && $stable(ref_q)));
  p_hold_result_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(found) && $stable(div_ref) && $stable(loopc)
               && $stable(div_out) && $stable(err_khz)));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/pll_param_search_tb.sv
module pll_param_search_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [19:0] req = '0;
  logic [16:0] refk = '0;
  logic        busy, done, found;
  logic [6:0]  div_ref, div_out;
  logic [8:0]  loopc;
  logic [25:0] err_khz;

  int tot = 0;
  int bad = 0;
  int cyc = 0;
  bit tmo = 1'b0;
  bit m_busy = 1'b0;
  logic [49:0] last_res = '0;

  always #5 clk = ~clk;

  pll_param_search #(.STEP(13)) u_dut (
    .clk(clk), .rst(rst), .start(start), .req_khz(req), .ref_khz(refk),
    .busy(busy), .done(done), .found(found), .div_ref(div_ref),
    .loopc(loopc), .div_out(div_out), .err_khz(err_khz)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) tmo <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: preset table, then ordered sweep.
  function automatic void model(input int rq, input int rf, output bit f,
                                output int dr, output int lc, output int dq,
                                output int er);
    int tk[10] = '{25175, 25200, 27000, 40000, 65000, 74250, 108000, 141750, 148500, 174500};
    int ta[10] = '{5, 5, 4, 3, 3, 3, 5, 5, 3, 3};
    int tb[10] = '{107, 63, 54, 36, 39, 49, 81, 78, 49, 89};
    int tc[10] = '{85, 50, 50, 30, 20, 22, 15, 11, 11, 17};
    int mn;
    int bdr, blc, bdq;
    for (int i = 0; i < 10; i++) begin
      if (rq == tk[i]) begin
        f = 1; dr = ta[i]; lc = tb[i]; dq = tc[i]; er = 0;
        return;
      end
    end
    mn = 1000; bdr = 0; blc = 0; bdq = 0;
    for (int o = 6; o <= 63; o++) begin
      for (int r = 3; r <= 5; r++) begin
        for (int l = 6; l <= 160; l++) begin
          int c, d;
          if (l < 12 * r || l > 32 * r) continue;
          c = ((rf / r) * l) / o;
          d = (c >= rq) ? c - rq : rq - c;
          if (d < mn) begin
            mn = d; bdr = r; blc = l; bdq = o;
            if (d == 0) begin
              f = 1; dr = r; lc = l; dq = o; er = 0;
              return;
            end
          end
        end
      end
    end
    f = (mn < 1000);
    er = mn;
    dr = f ? bdr : 0; lc = f ? blc : 0; dq = f ? bdq : 0;
  endfunction

  // Per-clock comparison of busy and of result holding (R10).
  always @(negedge clk) begin
    if (rst) begin
      m_busy = 1'b0;
    end else if (!tmo) begin
      if (done) m_busy = 1'b0;
      tot++;
      if (busy !== m_busy) begin
        bad++;
        $display("FAIL R10 busy: actual=%0d expected=%0d", busy, m_busy);
      end
      if (!done) begin
        tot++;
        if ({found, div_ref, loopc, div_out, err_khz} !== last_res) begin
          bad++;
          $display("FAIL R10 hold: actual=%0h expected=%0h",
                   {found, div_ref, loopc, div_out, err_khz}, last_res);
        end
      end else begin
        last_res = {found, div_ref, loopc, div_out, err_khz};
      end
      if (start && !busy) m_busy = 1'b1;
    end
  end

  task automatic run(input int rq, input int rf, input string tag,
                     input int ign_at = -1, input int ign_req = 0);
    bit ef;
    int edr, elc, edq, eer;
    model(rq, rf, ef, edr, elc, edq, eer);
    @(posedge clk); #1;
    start = 1'b1; req = 20'(rq); refk = 17'(rf);
    @(posedge clk); #1;
    start = 1'b0;
    if (ign_at >= 0) begin
      repeat (ign_at) @(posedge clk);
      #1;
      start = 1'b1; req = 20'(ign_req);
      @(posedge clk); #1;
      start = 1'b0;
    end
    do @(negedge clk); while (!done && !tmo);
    chk(found == ef, tag, "found", int'(found), int'(ef));
    chk(int'(div_ref) == edr, tag, "div_ref", int'(div_ref), edr);
    chk(int'(loopc) == elc, tag, "loopc", int'(loopc), elc);
    chk(int'(div_out) == edq, tag, "div_out", int'(div_out), edq);
    chk(int'(err_khz) == eer, tag, "err_khz", int'(err_khz), eer);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !found, "R11", "busy|done|found", int'({busy, done, found}), 0);
    chk(div_ref == 0 && loopc == 0 && div_out == 0 && err_khz == 0, "R11", "result",
        int'(err_khz) + int'(loopc), 0);

    // R8: preset hits, including entries whose sweep answer differs
    run(148500, 100000, "R8");
    chk(div_ref == 3 && loopc == 49 && div_out == 11, "R8", "148500 loopc", int'(loopc), 49);
    run(65000, 100000, "R8");
    run(25175, 100000, "R8");
    chk(div_out == 85, "R8", "25175 div_out", int'(div_out), 85);
    run(148500, 96000, "R8");

    // R7 / R4: exact hit on the first candidate, also reachable later
    run(199998, 100000, "R7");
    chk(div_ref == 3 && loopc == 36 && div_out == 6, "R4", "first tie loopc", int'(loopc), 36);
    run(192000, 96000, "R7");
    // R1: truncating first and second division
    run(178571, 100000, "R1");

    // R5 / R4 / R3 / R2: best error 999 above the top frequency
    run(534332, 100000, "R5");
    chk(div_ref == 4 && loopc == 128 && div_out == 6, "R3", "upper multiplier", int'(loopc), 128);
    chk(err_khz == 999, "R2", "edge error", int'(err_khz), 999);

    // R6 / R9: error exactly at tolerance fails; a start during the sweep is ignored
    run(534333, 100000, "R6", 40, 148500);
    chk(!found && err_khz == 1000, "R9", "ignored start err", int'(err_khz), 1000);

    if (tmo) begin
      tot++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
    end
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule